// File: doc/BRIEF.md
# Trap-Level Privileged Register File

This block holds the control and status registers of a processor core that sit outside the general register windows. A small five-bit index selects one register. There is a combinational read port and a write port. Each port checks the access against the current privilege mode, and returns a fault class in the same cycle as the request. A faulting read returns zero. A faulting write leaves all state unchanged.

Five trap-state registers are stacked, with one copy for each trap level. These are the trap PC, the trap next-PC, the trap state, the trap type and the hyper trap state. Accesses reach the copy at the current trap level minus one, so the trap handlers at each nesting depth keep their own saved state.

Writes to the trap level and to the global level are limited to a ceiling that depends on the privilege mode. A write to the global level, or to the window pointer, also raises a one-cycle context-change strobe carrying the value actually stored. This strobe lets the register-window logic outside the block follow the change.

Top module: `trap_ctl_regfile`

## Requirements
- R1: After reset, the registers hold these values:
  - The trap level reads MAX_TL (6) and the global level reads MAX_GL (3).
  - The trap type at that trap level reads the power-on code POR_TT (1).
  - The soft-interrupt register reads 0.
  - The processor state reads only bit PEF_BIT (4) set, which is 0x10.
  - The hyper state reads only bits RED_BIT (5) and HPRIV_BIT (2) set, which is 0x24.
  - The three timer-compare registers (indices 7, 8, 9) read only bit DW-1 set.
- R2: Indices 10 to 14 are the trap PC, trap next-PC, trap state, trap type and hyper trap state. Each has one entry per trap level 1..MAX_TL. Reads and writes use the entry of the current trap level, and values written at different levels are kept apart.
- R3: Any access to indices 10 to 14 while the trap level is 0 gives fault code 1. Such a read returns 0, and such a write changes nothing.
- R4: A fault-free write to the trap level (index 17) is handled by mode. In hyperprivileged mode it stores min(value, MAX_TL = 6). In privileged mode it stores min(value, MAX_PTL = 2).
- R5: A fault-free write to the global level (index 25) stores min(value, MAX_GL = 3) in hyperprivileged mode, and min(value, MAX_PGL = 2) in privileged mode. In the same cycle it raises glob_chg_o with glob_chg_lvl_o equal to the stored value.
- R6: A fault-free write to the window pointer (index 19) stores the value modulo NWIN (8). In the same cycle it raises win_chg_o with win_chg_ptr_o equal to the stored pointer.
- R7: The trap base (index 15) always reads with bits 14:0 equal to zero, whatever value was written.
- R8: The version register (index 28) reads NWIN | MAX_TL<<8 | MAX_GL<<16, which is 0x030608. A write to it gives fault code 1.
- R9: The program counter index (2) reads pc_i. A write to it gives fault code 1.
- R10: The unimplemented indices 3, 4 and 5 give fault code 4 on both ports. The unassigned indices 29 to 31 give fault code 1.
- R11: Access rights depend on the mode:
  - Indices 0 to 2 are open to every mode.
  - Indices 9, 14, 26, 27 and 28 need hyperprivileged mode (hpriv_i).
  - All other implemented indices need privileged mode or higher.
  - An access from user mode that lacks the right gives code 3. An access from privileged mode that lacks the right gives code 2.
  - A faulting write changes no state and raises no strobe.
- R12: Fault codes are 0 none, 1 illegal instruction, 2 privileged action, 3 privileged opcode and 4 unimplemented. They appear in the same cycle as the request. When several apply, the priority order is: unassigned, then unimplemented, then privilege, then trap level 0, then read-only target.
- R13: The plain registers are indices 0, 1, 6, 7, 8, 9, 16, 18, 20 to 24, 26 and 27. Each stores and returns the full DW-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Privileged mode |
| hpriv_i | input | 1 | Hyperprivileged mode (overrides priv_i) |
| pc_i | input | DW | Current program counter, returned on index 2 |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 5 | Read register index |
| rd_data_o | output | DW | Read data, 0 on fault or idle |
| rd_fault_o | output | 3 | Read fault class |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | DW | Write data |
| wr_fault_o | output | 3 | Write fault class |
| glob_chg_o | output | 1 | Global-level context change strobe |
| glob_chg_lvl_o | output | $clog2(MAX_GL+1) | Stored global level |
| win_chg_o | output | 1 | Window context change strobe |
| win_chg_ptr_o | output | $clog2(NWIN) | Stored window pointer |

## Verification
The fault decoder is swept over all 32 indices in each of the three modes. This pattern separates the priority between unassigned, unimplemented, privilege and trap-level-zero faults, and checks that every faulting read returns zero.

The level registers are driven with values from 0 up to well beyond their ceilings, in both privileged and hyperprivileged mode. This pattern separates the two ceilings and checks the value carried by each strobe.

The trap-state stack is filled with a distinct value at every level and then read back in reverse order. A mix-up between levels therefore shows up, and so does an access at level 0.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

   localparam int IDX_W      = 5;
   localparam int NUM_IDX    = 1 << IDX_W;
   localparam int NUM_BANKED = 5;
   localparam int BANK_BASE  = 10;

   typedef enum logic [IDX_W-1:0] {
      RI_CCODE       = 5'd0,
      RI_ASPACE      = 5'd1,
      RI_PCNT        = 5'd2,
      RI_FPSTAT      = 5'd3,
      RI_PERFCTL     = 5'd4,
      RI_PERFCNT     = 5'd5,
      RI_SOFTINT     = 5'd6,
      RI_TMR_CMP     = 5'd7,
      RI_STMR_CMP    = 5'd8,
      RI_HTMR_CMP    = 5'd9,
      RI_TRAP_PC     = 5'd10,
      RI_TRAP_NPC    = 5'd11,
      RI_TRAP_STATE  = 5'd12,
      RI_TRAP_TYPE   = 5'd13,
      RI_HTRAP_STATE = 5'd14,
      RI_TRAP_BASE   = 5'd15,
      RI_PSTATE      = 5'd16,
      RI_TRAP_LVL    = 5'd17,
      RI_IRQ_LVL     = 5'd18,
      RI_WIN_PTR     = 5'd19,
      RI_WIN_SAVE    = 5'd20,
      RI_WIN_REST    = 5'd21,
      RI_WIN_CLEAN   = 5'd22,
      RI_WIN_OTHER   = 5'd23,
      RI_WIN_STATE   = 5'd24,
      RI_GLOB_LVL    = 5'd25,
      RI_HSTATE      = 5'd26,
      RI_HTRAP_BASE  = 5'd27,
      RI_HWVER       = 5'd28
   } reg_idx_e;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ILLEGAL  = 3'd1,
      FLT_PRIV_ACT = 3'd2,
      FLT_PRIV_OPC = 3'd3,
      FLT_UNIMPL   = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      MODE_USER  = 2'd0,
      MODE_PRIV  = 2'd1,
      MODE_HYPER = 2'd2
   } mode_e;

   function automatic logic is_banked(logic [IDX_W-1:0] idx);
      return (idx >= RI_TRAP_PC) && (idx <= RI_HTRAP_STATE);
   endfunction

   function automatic logic is_unimpl(logic [IDX_W-1:0] idx);
      return (idx >= RI_FPSTAT) && (idx <= RI_PERFCNT);
   endfunction

   function automatic logic is_plain(logic [IDX_W-1:0] idx);
      return (idx == RI_CCODE) || (idx == RI_ASPACE) ||
             ((idx >= RI_SOFTINT) && (idx <= RI_HTMR_CMP)) ||
             (idx == RI_TRAP_BASE) || (idx == RI_PSTATE) || (idx == RI_IRQ_LVL) ||
             ((idx >= RI_WIN_SAVE) && (idx <= RI_WIN_STATE)) ||
             (idx == RI_HSTATE) || (idx == RI_HTRAP_BASE);
   endfunction

   // Lowest mode allowed to touch an index: 0 user, 1 privileged, 2 hyper
   function automatic logic [1:0] need_mode(logic [IDX_W-1:0] idx);
      if (idx <= RI_PCNT) return 2'd0;
      if ((idx == RI_HTMR_CMP) || (idx == RI_HTRAP_STATE) || (idx == RI_HSTATE) ||
          (idx == RI_HTRAP_BASE) || (idx == RI_HWVER)) return 2'd2;
      return 2'd1;
   endfunction

endpackage

// File: rtl/tcr_access_chk.sv
module tcr_access_chk
   import tcr_pkg::*;
#(
   parameter bit IS_WRITE = 1'b0,
   parameter int LVL_W    = 3
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  mode_e            mode,
   input  logic [LVL_W-1:0] tl,
   output fault_e           fault
);

   logic ro_target;

   generate
      if (IS_WRITE) begin : g_wr
         assign ro_target = (idx == RI_PCNT) || (idx == RI_HWVER);
      end else begin : g_rd
         assign ro_target = 1'b0;
      end
   endgenerate

   always_comb begin
      fault = FLT_NONE;
      if (en) begin
         if (idx > RI_HWVER)
            fault = FLT_ILLEGAL;
         else if (is_unimpl(idx))
            fault = FLT_UNIMPL;
         else if (2'(mode) < need_mode(idx))
            fault = (mode == MODE_USER) ? FLT_PRIV_OPC : FLT_PRIV_ACT;
         else if (is_banked(idx) && (tl == '0))
            fault = FLT_ILLEGAL;
         else if (ro_target)
            fault = FLT_ILLEGAL;
      end
   end

endmodule

// File: rtl/tcr_lvl_clamp.sv
module tcr_lvl_clamp
   import tcr_pkg::*;
#(
   parameter int IN_W  = 64,
   parameter int OUT_W = 3,
   parameter int MAX_H = 6,
   parameter int MAX_P = 2
) (
   input  logic [IN_W-1:0]  val,
   input  mode_e            mode,
   output logic [OUT_W-1:0] lvl
);

   generate
      if (MAX_P > MAX_H) begin : g_bad_order
         $error("privileged ceiling above hyper ceiling");
      end
      if (MAX_H >= (1 << OUT_W)) begin : g_bad_width
         $error("ceiling does not fit the level width");
      end
   endgenerate

   always_comb begin
      if ((mode == MODE_HYPER) && (val > IN_W'(MAX_H)))
         lvl = OUT_W'(MAX_H);
      else if ((mode == MODE_PRIV) && (val > IN_W'(MAX_P)))
         lvl = OUT_W'(MAX_P);
      else
         lvl = val[OUT_W-1:0];
   end

endmodule

// File: rtl/tcr_trap_stack.sv
module tcr_trap_stack
   import tcr_pkg::*;
#(
   parameter int DW     = 64,
   parameter int DEPTH  = 6,
   parameter int LVL_W  = 3,
   parameter int NREG   = NUM_BANKED,
   parameter int TT_SEL = 3,
   parameter int POR_TT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] tl,
   input  logic [2:0]       rd_sel,
   output logic [DW-1:0]    rd_data,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [DW-1:0]    wr_data
);

   logic [LVL_W-1:0] slot;
   logic             slot_ok;
   logic [DW-1:0]    rd_vec [NREG];

   assign slot    = tl - LVL_W'(1);
   assign slot_ok = (tl != '0) && (32'(slot) < DEPTH);

   for (genvar r = 0; r < NREG; r++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
               mem[e] <= ((r == TT_SEL) && (e == DEPTH - 1)) ? DW'(POR_TT) : '0;
            end
         end else if (wr_en && slot_ok && (32'(wr_sel) == r)) begin
            mem[slot] <= wr_data;
         end
      end

      assign rd_vec[r] = slot_ok ? mem[slot] : '0;
   end

   assign rd_data = (32'(rd_sel) < NREG) ? rd_vec[rd_sel] : '0;

endmodule

// File: rtl/trap_ctl_regfile.sv
module trap_ctl_regfile
   import tcr_pkg::*;
#(
   parameter int DW        = 64,
   parameter int NWIN      = 8,
   parameter int MAX_TL    = 6,
   parameter int MAX_PTL   = 2,
   parameter int MAX_GL    = 3,
   parameter int MAX_PGL   = 2,
   parameter int POR_TT    = 1,
   parameter int PEF_BIT   = 4,
   parameter int RED_BIT   = 5,
   parameter int HPRIV_BIT = 2,
   parameter int BASE_LSB  = 15,
   parameter int GLW_P     = $clog2(MAX_GL + 1),
   parameter int CWP_P     = $clog2(NWIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             priv_i,
   input  logic             hpriv_i,
   input  logic [DW-1:0]    pc_i,
   input  logic             rd_en_i,
   input  logic [4:0]       rd_idx_i,
   output logic [DW-1:0]    rd_data_o,
   output logic [2:0]       rd_fault_o,
   input  logic             wr_en_i,
   input  logic [4:0]       wr_idx_i,
   input  logic [DW-1:0]    wr_data_i,
   output logic [2:0]       wr_fault_o,
   output logic             glob_chg_o,
   output logic [GLW_P-1:0] glob_chg_lvl_o,
   output logic             win_chg_o,
   output logic [CWP_P-1:0] win_chg_ptr_o
);

   localparam int LVL_W = $clog2(MAX_TL + 1);
   localparam int GLW   = GLW_P;
   localparam int CWP_W = CWP_P;
   localparam logic [DW-1:0] BASE_MASK = ~((DW'(1) << BASE_LSB) - DW'(1));
   localparam logic [DW-1:0] HWVER_VAL =
      DW'(NWIN) | (DW'(MAX_TL) << 8) | (DW'(MAX_GL) << 16);
   localparam int TT_SEL = int'(RI_TRAP_TYPE) - BANK_BASE;

   generate
      if (DW < 24)                       begin : g_bad_dw   $error("data width too small for version word"); end
      if ((1 << CWP_W) != NWIN)          begin : g_bad_nwin $error("window count must be a power of two"); end
      if (BASE_LSB >= DW)                begin : g_bad_base $error("base alignment exceeds data width"); end
      if ((PEF_BIT >= DW) || (RED_BIT >= DW) || (HPRIV_BIT >= DW)) begin : g_bad_bit
         $error("reset bit position outside data width");
      end
   endgenerate

   function automatic logic [DW-1:0] reset_val(logic [IDX_W-1:0] i);
      case (i)
         RI_TMR_CMP, RI_STMR_CMP, RI_HTMR_CMP: return DW'(1) << (DW - 1);
         RI_PSTATE:  return DW'(1) << PEF_BIT;
         RI_HSTATE:  return (DW'(1) << RED_BIT) | (DW'(1) << HPRIV_BIT);
         default:    return '0;
      endcase
   endfunction

   // ---------------------------------------------------------------- mode
   mode_e mode;
   assign mode = hpriv_i ? MODE_HYPER : (priv_i ? MODE_PRIV : MODE_USER);

   // ---------------------------------------------------------------- levels
   logic [LVL_W-1:0] tl_q;
   logic [GLW-1:0]   gl_q;
   logic [CWP_W-1:0] wp_q;

   // ---------------------------------------------------------------- checks
   fault_e rd_flt, wr_flt;

   tcr_access_chk #(.IS_WRITE(1'b0), .LVL_W(LVL_W)) u_rd_chk (
      .en(rd_en_i), .idx(rd_idx_i), .mode(mode), .tl(tl_q), .fault(rd_flt));

   tcr_access_chk #(.IS_WRITE(1'b1), .LVL_W(LVL_W)) u_wr_chk (
      .en(wr_en_i), .idx(wr_idx_i), .mode(mode), .tl(tl_q), .fault(wr_flt));

   assign rd_fault_o = rd_flt;
   assign wr_fault_o = wr_flt;

   logic wr_ok;
   assign wr_ok = wr_en_i && (wr_flt == FLT_NONE);

   // ---------------------------------------------------------------- clamps
   logic [LVL_W-1:0] tl_new;
   logic [GLW-1:0]   gl_new;

   tcr_lvl_clamp #(.IN_W(DW), .OUT_W(LVL_W), .MAX_H(MAX_TL), .MAX_P(MAX_PTL)) u_tl_clamp (
      .val(wr_data_i), .mode(mode), .lvl(tl_new));

   tcr_lvl_clamp #(.IN_W(DW), .OUT_W(GLW), .MAX_H(MAX_GL), .MAX_P(MAX_PGL)) u_gl_clamp (
      .val(wr_data_i), .mode(mode), .lvl(gl_new));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl_q <= LVL_W'(MAX_TL);
         gl_q <= GLW'(MAX_GL);
         wp_q <= '0;
      end else if (wr_ok) begin
         if (wr_idx_i == RI_TRAP_LVL) tl_q <= tl_new;
         if (wr_idx_i == RI_GLOB_LVL) gl_q <= gl_new;
         if (wr_idx_i == RI_WIN_PTR)  wp_q <= wr_data_i[CWP_W-1:0];
      end
   end

   // ---------------------------------------------------------------- strobes
   assign glob_chg_o     = wr_ok && (wr_idx_i == RI_GLOB_LVL);
   assign glob_chg_lvl_o = glob_chg_o ? gl_new : '0;
   assign win_chg_o      = wr_ok && (wr_idx_i == RI_WIN_PTR);
   assign win_chg_ptr_o  = win_chg_o ? wr_data_i[CWP_W-1:0] : '0;

   // ---------------------------------------------------------------- trap stack
   logic [DW-1:0] bank_rd;
   logic [2:0]    bank_rd_sel, bank_wr_sel;

   assign bank_rd_sel = 3'(rd_idx_i - 5'(BANK_BASE));
   assign bank_wr_sel = 3'(wr_idx_i - 5'(BANK_BASE));

   tcr_trap_stack #(
      .DW(DW), .DEPTH(MAX_TL), .LVL_W(LVL_W), .NREG(NUM_BANKED),
      .TT_SEL(TT_SEL), .POR_TT(POR_TT)
   ) u_stack (
      .clk(clk), .rst_n(rst_n), .tl(tl_q),
      .rd_sel(bank_rd_sel), .rd_data(bank_rd),
      .wr_en(wr_ok && is_banked(wr_idx_i)), .wr_sel(bank_wr_sel), .wr_data(wr_data_i));

   // ---------------------------------------------------------------- plain registers
   logic [DW-1:0] wr_val;
   logic [DW-1:0] flat_q [NUM_IDX];

   assign wr_val = (wr_idx_i == RI_TRAP_BASE) ? (wr_data_i & BASE_MASK) : wr_data_i;

   for (genvar i = 0; i < NUM_IDX; i++) begin : g_flat
      if (is_plain(IDX_W'(i))) begin : g_store
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= reset_val(IDX_W'(i));
            else if (wr_ok && (32'(wr_idx_i) == i))
               q <= wr_val;
         end
         assign flat_q[i] = q;
      end else begin : g_none
         assign flat_q[i] = '0;
      end
   end

   // ---------------------------------------------------------------- read mux
   logic [DW-1:0] rd_raw;

   always_comb begin
      if (is_banked(rd_idx_i)) begin
         rd_raw = bank_rd;
      end else begin
         case (rd_idx_i)
            RI_PCNT:      rd_raw = pc_i;
            RI_TRAP_LVL:  rd_raw = DW'(tl_q);
            RI_GLOB_LVL:  rd_raw = DW'(gl_q);
            RI_WIN_PTR:   rd_raw = DW'(wp_q);
            RI_HWVER:     rd_raw = HWVER_VAL;
            RI_TRAP_BASE: rd_raw = flat_q[rd_idx_i] & BASE_MASK;
            default:      rd_raw = flat_q[rd_idx_i];
         endcase
      end
      rd_data_o = (rd_en_i && (rd_flt == FLT_NONE)) ? rd_raw : '0;
   end

   // ---------------------------------------------------------------- assertions
   p_fault_blanks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fault_o != 3'd0) |-> (rd_data_o == '0));

   p_lvl0_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && hpriv_i && is_banked(rd_idx_i) && (tl_q == '0)) |-> (rd_fault_o == 3'd1));

   p_tl_priv_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_idx_i == RI_TRAP_LVL) && priv_i && !hpriv_i && (wr_fault_o == 3'd0))
      |=> (32'(tl_q) <= MAX_PTL));

   p_gl_hyper_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_idx_i == RI_GLOB_LVL) && hpriv_i && (wr_fault_o == 3'd0))
      |=> (32'(gl_q) <= MAX_GL));

   p_glob_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      glob_chg_o |=> (gl_q == $past(glob_chg_lvl_o)));

   p_win_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_chg_o |=> (wp_q == $past(win_chg_ptr_o)));

   p_base_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && (rd_idx_i == RI_TRAP_BASE)) |-> (rd_data_o[BASE_LSB-1:0] == '0));

   p_unimpl_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && is_unimpl(wr_idx_i)) |-> (wr_fault_o == 3'd4));

   p_no_strobe_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fault_o != 3'd0) |-> (!glob_chg_o && !win_chg_o));

endmodule

// File: tb/trap_ctl_regfile_tb.sv
module trap_ctl_regfile_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW      = 64;
   localparam int MAX_TL  = 6;
   localparam int MAX_PTL = 2;
   localparam int MAX_GL  = 3;
   localparam int MAX_PGL = 2;
   localparam int NWIN    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          priv_i = 1'b0, hpriv_i = 1'b1;
   logic [DW-1:0] pc_i = '0;
   logic          rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0]    rd_idx = '0, wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [2:0]    rd_fault, wr_fault;
   logic          glob_chg, win_chg;
   logic [1:0]    glob_lvl;
   logic [2:0]    win_ptr;

   trap_ctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .hpriv_i(hpriv_i), .pc_i(pc_i),
      .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_fault_o(rd_fault),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_fault_o(wr_fault),
      .glob_chg_o(glob_chg), .glob_chg_lvl_o(glob_lvl),
      .win_chg_o(win_chg), .win_chg_ptr_o(win_ptr));

   int n_chk = 0;
   int n_fail = 0;

   // values seen during the last write
   logic [2:0] s_flt;
   logic       s_gs, s_ws;
   logic [1:0] s_gv;
   logic [2:0] s_wv;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_mode(input int m);
      hpriv_i = (m == 2);
      priv_i  = (m == 1);
   endtask

   task automatic rd(input int idx, output logic [63:0] d, output logic [2:0] f);
      @(negedge clk);
      rd_en = 1'b1; rd_idx = 5'(idx);
      #1;
      d = rd_data; f = rd_fault;
      rd_en = 1'b0;
   endtask

   task automatic wr(input int idx, input logic [63:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_data = v;
      #1;
      s_flt = wr_fault; s_gs = glob_chg; s_gv = glob_lvl; s_ws = win_chg; s_wv = win_ptr;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   // fault class computed from R10, R11, R12, R3, R8, R9
   function automatic int exp_fault(int idx, int m, int tl, bit is_wr);
      int need;
      if (idx > 28) return 1;
      if (idx >= 3 && idx <= 5) return 4;
      if (idx <= 2) need = 0;
      else if (idx == 9 || idx == 14 || idx == 26 || idx == 27 || idx == 28) need = 2;
      else need = 1;
      if (m < need) return (m == 0) ? 3 : 2;
      if (idx >= 10 && idx <= 14 && tl == 0) return 1;
      if (is_wr && (idx == 2 || idx == 28)) return 1;
      return 0;
   endfunction

   function automatic logic [63:0] bank_val(int r, int lvl);
      return 64'hC3C3_0000_0000_0000 | 64'(r * 256 + lvl);
   endfunction

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] d;
      logic [2:0]  f;
      int          gl_now;
      int          plain [15] = '{0, 1, 6, 7, 8, 9, 16, 18, 20, 21, 22, 23, 24, 26, 27};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      set_mode(2);

      // R1 reset state
      rd(17, d, f); check("R1 trap level", d, 64'd6);
      rd(25, d, f); check("R1 global level", d, 64'd3);
      rd(13, d, f); check("R1 trap type POR", d, 64'd1);
      check("R1 fault none", 64'(f), 64'd0);
      rd(6, d, f);  check("R1 softint", d, 64'd0);
      rd(16, d, f); check("R1 pstate", d, 64'h10);
      rd(26, d, f); check("R1 hstate", d, 64'h24);
      for (int i = 7; i <= 9; i++) begin
         rd(i, d, f); check("R1 timer compare", d, 64'h8000_0000_0000_0000);
      end
      rd(10, d, f); check("R1 trap pc clear", d, 64'd0);

      // R2 per-level stacking
      for (int lvl = 1; lvl <= MAX_TL; lvl++) begin
         wr(17, 64'(lvl));
         for (int r = 0; r < 5; r++) wr(10 + r, bank_val(r, lvl));
      end
      for (int lvl = MAX_TL; lvl >= 1; lvl--) begin
         wr(17, 64'(lvl));
         for (int r = 0; r < 5; r++) begin
            rd(10 + r, d, f); check("R2 banked readback", d, bank_val(r, lvl));
         end
      end

      // R3 trap level zero
      wr(17, 64'd0);
      for (int r = 0; r < 5; r++) begin
         rd(10 + r, d, f);
         check("R3 read fault", 64'(f), 64'd1);
         check("R3 read data zero", d, 64'd0);
         wr(10 + r, 64'hFFFF);
         check("R3 write fault", 64'(s_flt), 64'd1);
      end
      wr(17, 64'd1);
      for (int r = 0; r < 5; r++) begin
         rd(10 + r, d, f); check("R3 level 1 untouched", d, bank_val(r, 1));
      end

      // R4 trap level clamp
      for (int m = 1; m <= 2; m++) begin
         for (int v = 0; v <= 10; v++) begin
            logic [63:0] val;
            val = (v == 10) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'(v);
            set_mode(m);
            wr(17, val);
            check("R4 write fault", 64'(s_flt), 64'd0);
            set_mode(2);
            rd(17, d, f);
            check("R4 clamped level", d,
                  64'((v == 10) ? ((m == 2) ? MAX_TL : MAX_PTL) : imin(v, (m == 2) ? MAX_TL : MAX_PTL)));
         end
      end

      // R5 global level clamp and strobe
      gl_now = MAX_GL;
      for (int m = 1; m <= 2; m++) begin
         for (int v = 0; v <= 7; v++) begin
            logic [63:0] val;
            int          e;
            val = (v == 7) ? 64'h8000_0000_0000_0003 : 64'(v);
            e = (v == 7) ? ((m == 2) ? MAX_GL : MAX_PGL) : imin(v, (m == 2) ? MAX_GL : MAX_PGL);
            set_mode(m);
            wr(25, val);
            check("R5 strobe", 64'(s_gs), 64'd1);
            check("R5 strobe value", 64'(s_gv), 64'(e));
            check("R5 no window strobe", 64'(s_ws), 64'd0);
            set_mode(2);
            rd(25, d, f); check("R5 stored level", d, 64'(e));
            gl_now = e;
         end
      end

      // R6 window pointer
      for (int v = 0; v <= 10; v++) begin
         wr(19, 64'(v) | 64'h100);
         check("R6 strobe", 64'(s_ws), 64'd1);
         check("R6 strobe value", 64'(s_wv), 64'(v % NWIN));
         check("R6 no global strobe", 64'(s_gs), 64'd0);
         rd(19, d, f); check("R6 stored pointer", d, 64'(v % NWIN));
      end

      // R7 trap base alignment
      wr(15, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(15, d, f); check("R7 base masked", d, 64'hFFFF_FFFF_FFFF_8000);
      wr(15, 64'h0001_2345);
      rd(15, d, f); check("R7 base masked small", d, 64'h0001_0000);

      // R8 version
      rd(28, d, f); check("R8 version", d, 64'h0003_0608);
      wr(28, 64'd0); check("R8 write fault", 64'(s_flt), 64'd1);
      rd(28, d, f); check("R8 version kept", d, 64'h0003_0608);

      // R9 program counter
      pc_i = 64'hDEAD_BEEF_0000_1234;
      set_mode(0);
      rd(2, d, f); check("R9 pc read", d, 64'hDEAD_BEEF_0000_1234);
      set_mode(2);
      wr(2, 64'd5); check("R9 pc write fault", 64'(s_flt), 64'd1);

      // R13 plain registers
      foreach (plain[k]) wr(plain[k], 64'hA5A5_0000_0000_0000 ^ 64'(plain[k] * 4099));
      foreach (plain[k]) begin
         rd(plain[k], d, f);
         check("R13 plain readback", d, 64'hA5A5_0000_0000_0000 ^ 64'(plain[k] * 4099));
      end

      // R10 / R12 read-fault sweep at trap level 2
      wr(17, 64'd2);
      for (int m = 0; m <= 2; m++) begin
         set_mode(m);
         for (int i = 0; i < 32; i++) begin
            int e;
            e = exp_fault(i, m, 2, 1'b0);
            rd(i, d, f);
            check("R12 read fault class", 64'(f), 64'(e));
            if (e != 0) check("R11 faulting read zero", d, 64'd0);
         end
      end

      // R11 user-mode write sweep
      set_mode(0);
      for (int i = 0; i < 32; i++) begin
         wr(i, 64'h5555_5555_5555_5555);
         check("R11 user write fault", 64'(s_flt), 64'(exp_fault(i, 0, 2, 1'b1)));
         if (i == 25) check("R11 no global strobe", 64'(s_gs), 64'd0);
         if (i == 19) check("R11 no window strobe", 64'(s_ws), 64'd0);
      end
      set_mode(1);
      wr(27, 64'h1234); check("R11 priv on hyper reg", 64'(s_flt), 64'd2);
      wr(14, 64'h1234); check("R11 priv on hyper trap state", 64'(s_flt), 64'd2);
      set_mode(2);
      rd(15, d, f); check("R11 trap base unchanged", d, 64'h0001_0000);
      rd(17, d, f); check("R11 trap level unchanged", d, 64'd2);
      rd(25, d, f); check("R11 global level unchanged", d, 64'(gl_now));
      rd(27, d, f); check("R11 hyper base unchanged", d, 64'hA5A5_0000_0000_0000 ^ 64'(27 * 4099));
      rd(14, d, f); check("R11 hyper trap state unchanged", d, bank_val(4, 2));
      rd(0, d, f);  check("R11 user write allowed", d, 64'h5555_5555_5555_5555);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule